// File: doc/BRIEF.md
# 40-bit Signed Multiply-Accumulate Unit

This block keeps one 40-bit signed accumulator and adds signed products of two 32-bit operands to it. An opcode picks one of three multiply forms. The first multiplies one 16-bit half of each operand, and each half is chosen on its own. The second is a dual 16-bit SIMD form that adds both the high-by-high and the low-by-low products. The third is a full 32x32 multiply, and only the low 40 bits of its 64-bit product are added. A load opcode writes the accumulator from two 32-bit words. The accumulator is always visible as a whole and as two 32-bit read words.

The 16-bit forms and the load finish in one cycle. The 32x32 form takes two cycles, because one 17x32 multiplier is used twice. During the second cycle the unit lowers `ready`, and any operation offered in that cycle is dropped. A synchronous clear has priority over everything else. Sums wrap modulo 2^40 and are never saturated.

Top module: `mac40_unit`

## Requirements
- R1: After reset the accumulator reads zero and `ready` is 1.
- R2: Opcode 3'd1 adds one signed 16x16 product, sign-extended to 40 bits. The multiplier factor is `op_a[31:16]` when `sel_a_hi` is 1, otherwise `op_a[15:0]`. The multiplicand factor is `op_b[31:16]` when `sel_b_hi` is 1, otherwise `op_b[15:0]`. The result shows on `acc_out` one cycle after the accepting edge.
- R3: Opcode 3'd2 adds the sign-extended products `op_a[31:16]*op_b[31:16]` and `op_a[15:0]*op_b[15:0]` in the same cycle. The half selects are ignored.
- R4: Opcode 3'd3 adds bits [39:0] of the signed 64-bit product `op_a*op_b`. The result shows two cycles after the accepting edge. `ready` is 0 for exactly the one cycle in between.
- R5: While `ready` is 0, an offered operation has no effect.
- R6: `rd_lo` equals accumulator bits [31:0]. `rd_hi` equals bits [39:32], sign-extended to 32 bits.
- R7: Opcode 3'd4 loads the accumulator with `op_a` in bits [31:0] and `op_b[7:0]` in bits [39:32].
- R8: Accumulation wraps modulo 2^40 with no saturation.
- R9: `clear` sets the accumulator to zero on the next edge. It overrides any offered operation, cancels a pending 32x32 second step, and leaves `ready` at 1.
- R10: Opcodes 3'd0, 3'd5, 3'd6 and 3'd7, and cycles with `op_valid` low, leave the accumulator unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Operation offered this cycle |
| op_code | input | 3 | Operation select |
| op_a | input | 32 | Multiplier operand / low load word |
| op_b | input | 32 | Multiplicand operand / high load word |
| sel_a_hi | input | 1 | 16x16 form: use the high half of op_a |
| sel_b_hi | input | 1 | 16x16 form: use the high half of op_b |
| clear | input | 1 | Synchronous accumulator clear |
| ready | output | 1 | Unit accepts an operation this cycle |
| acc_out | output | 40 | Accumulator value |
| rd_lo | output | 32 | Accumulator bits [31:0] |
| rd_hi | output | 32 | Accumulator bits [39:32], sign-extended |

## Verification
The 16-bit forms, the load and the clear are due one edge after they are accepted. A 32x32 result is due two edges after it is accepted, and `ready` is expected low one edge after acceptance. The driver records each expected item together with the cycle number in which it falls due. The monitor compares an item only at the falling edge of that cycle. The cycle between the two steps of a 32x32 multiply is checked only for `ready` being low. In that same cycle the bench offers a stray load or asserts clear, to test R5 and R9.

// File: rtl/mac40_pkg.sv
package mac40_pkg;
  localparam logic [2:0] OP_NOP   = 3'd0;
  localparam logic [2:0] OP_MUL16 = 3'd1;
  localparam logic [2:0] OP_DUAL  = 3'd2;
  localparam logic [2:0] OP_MUL32 = 3'd3;
  localparam logic [2:0] OP_LOAD  = 3'd4;
endpackage

// File: rtl/mac40_lane.sv
// Signed HALF_W x HALF_W multiplier lane, full-width product.
module mac40_lane #(
  parameter int HALF_W = 16
) (
  input  logic [HALF_W-1:0]   x,
  input  logic [HALF_W-1:0]   y,
  output logic [2*HALF_W-1:0] p
);
  logic signed [2*HALF_W-1:0] xs, ys;
  always_comb begin
    xs = {{HALF_W{x[HALF_W-1]}}, x};
    ys = {{HALF_W{y[HALF_W-1]}}, y};
    p  = xs * ys;
  end
endmodule

// File: rtl/mac40_part.sv
// One step of the two-step wide multiply: signed a times a 17-bit signed slice,
// optionally weighted by 2^HALF_W, reduced modulo 2^ACC_W.
module mac40_part #(
  parameter int DATA_W = 32,
  parameter int ACC_W  = 40,
  localparam int HALF_W = DATA_W / 2
) (
  input  logic [DATA_W-1:0] a,
  input  logic [HALF_W:0]   bs,
  input  logic              upper,
  output logic [ACC_W-1:0]  addend
);
  logic signed [ACC_W-1:0] ax, bx, prod;
  always_comb begin
    ax   = {{(ACC_W-DATA_W){a[DATA_W-1]}}, a};
    bx   = {{(ACC_W-HALF_W-1){bs[HALF_W]}}, bs};
    prod = ax * bx;
    addend = upper ? (prod << HALF_W) : prod;
  end
endmodule

// File: rtl/mac40_accreg.sv
// Accumulator register, wide-multiply sequencing and reset synchronizer.
module mac40_accreg
  import mac40_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ACC_W  = 40,
  localparam int HALF_W = DATA_W / 2,
  localparam int TOP_W  = ACC_W - DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic [2:0]        op_code,
  input  logic [DATA_W-1:0] op_a,
  input  logic [HALF_W-1:0] b_hi,
  input  logic [TOP_W-1:0]  load_top,
  input  logic              clear,
  input  logic [ACC_W-1:0]  add_narrow,
  input  logic [ACC_W-1:0]  add_wide,
  output logic              busy,
  output logic [DATA_W-1:0] a_hold,
  output logic [HALF_W-1:0] bhi_hold,
  output logic [ACC_W-1:0]  acc
);
  logic [1:0]        rst_pipe;
  logic              rst_ok;
  logic [ACC_W-1:0]  acc_d;
  logic              acc_en, busy_d, hold_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_ok = rst_pipe[1];

  always_comb begin
    acc_d   = acc;
    acc_en  = 1'b0;
    busy_d  = 1'b0;
    hold_en = 1'b0;
    if (clear) begin
      acc_d  = '0;
      acc_en = 1'b1;
    end else if (busy) begin
      acc_d  = acc + add_wide;
      acc_en = 1'b1;
    end else if (op_valid) begin
      unique case (op_code)
        OP_MUL16, OP_DUAL: begin
          acc_d  = acc + add_narrow;
          acc_en = 1'b1;
        end
        OP_MUL32: begin
          acc_d   = acc + add_wide;
          acc_en  = 1'b1;
          busy_d  = 1'b1;
          hold_en = 1'b1;
        end
        OP_LOAD: begin
          acc_d  = {load_top, op_a};
          acc_en = 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_ok) begin
    if (!rst_ok) begin
      acc      <= '0;
      busy     <= 1'b0;
      a_hold   <= '0;
      bhi_hold <= '0;
    end else begin
      busy <= busy_d;
      if (acc_en)  acc <= acc_d;
      if (hold_en) begin
        a_hold   <= op_a;
        bhi_hold <= b_hi;
      end
    end
  end

  logic issue_wide, op_known;
  assign issue_wide = !clear && !busy && op_valid && (op_code == OP_MUL32);
  assign op_known   = op_code inside {OP_MUL16, OP_DUAL, OP_MUL32, OP_LOAD};

  p_wide_busy_r4: assert property (@(posedge clk) disable iff (!rst_ok)
    issue_wide |=> busy);
  p_busy_single_r4: assert property (@(posedge clk) disable iff (!rst_ok)
    busy |=> !busy);
  p_clear_zero_r9: assert property (@(posedge clk) disable iff (!rst_ok)
    clear |=> (acc == '0) && !busy);
  p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_ok)
    (!clear && !busy && !(op_valid && op_known)) |=> $stable(acc));
  p_load_word_r7: assert property (@(posedge clk) disable iff (!rst_ok)
    (!clear && !busy && op_valid && op_code == OP_LOAD)
      |=> acc == {$past(load_top), $past(op_a)});
endmodule

// File: rtl/mac40_unit.sv
module mac40_unit
  import mac40_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ACC_W  = 40,
  localparam int HALF_W = DATA_W / 2,
  localparam int TOP_W  = ACC_W - DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic [2:0]        op_code,
  input  logic [DATA_W-1:0] op_a,
  input  logic [DATA_W-1:0] op_b,
  input  logic              sel_a_hi,
  input  logic              sel_b_hi,
  input  logic              clear,
  output logic              ready,
  output logic [ACC_W-1:0]  acc_out,
  output logic [DATA_W-1:0] rd_lo,
  output logic [DATA_W-1:0] rd_hi
);
  logic [HALF_W-1:0]   a_lo, a_hi, b_lo, b_hi;
  logic [HALF_W-1:0]   lx [2];
  logic [HALF_W-1:0]   ly [2];
  logic [2*HALF_W-1:0] lp [2];
  logic                dual;
  logic [ACC_W-1:0]    add_narrow, add_wide, acc;
  logic                busy;
  logic [DATA_W-1:0]   a_hold, part_a;
  logic [HALF_W-1:0]   bhi_hold;
  logic [HALF_W:0]     part_b;

  assign a_lo = op_a[HALF_W-1:0];
  assign a_hi = op_a[DATA_W-1:HALF_W];
  assign b_lo = op_b[HALF_W-1:0];
  assign b_hi = op_b[DATA_W-1:HALF_W];
  assign dual = (op_code == OP_DUAL);

  // Lane 0: selected halves (or low/low in dual mode). Lane 1: high/high.
  assign lx[0] = (!dual && sel_a_hi) ? a_hi : a_lo;
  assign ly[0] = (!dual && sel_b_hi) ? b_hi : b_lo;
  assign lx[1] = a_hi;
  assign ly[1] = b_hi;

  for (genvar i = 0; i < 2; i++) begin : g_lane
    mac40_lane #(.HALF_W(HALF_W)) u_lane (.x(lx[i]), .y(ly[i]), .p(lp[i]));
  end

  always_comb begin
    add_narrow = {{(ACC_W-2*HALF_W){lp[0][2*HALF_W-1]}}, lp[0]};
    if (dual)
      add_narrow = add_narrow + {{(ACC_W-2*HALF_W){lp[1][2*HALF_W-1]}}, lp[1]};
  end

  // Step 1: a * unsigned low half of b. Step 2: a * signed high half, << HALF_W.
  assign part_a = busy ? a_hold : op_a;
  assign part_b = busy ? {bhi_hold[HALF_W-1], bhi_hold} : {1'b0, b_lo};

  mac40_part #(.DATA_W(DATA_W), .ACC_W(ACC_W)) u_part (
    .a(part_a), .bs(part_b), .upper(busy), .addend(add_wide)
  );

  mac40_accreg #(.DATA_W(DATA_W), .ACC_W(ACC_W)) u_acc (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .op_a(op_a), .b_hi(b_hi), .load_top(op_b[TOP_W-1:0]), .clear(clear),
    .add_narrow(add_narrow), .add_wide(add_wide), .busy(busy),
    .a_hold(a_hold), .bhi_hold(bhi_hold), .acc(acc)
  );

  assign ready   = !busy;
  assign acc_out = acc;
  assign rd_lo   = acc[DATA_W-1:0];
  assign rd_hi   = {{(2*DATA_W-ACC_W){acc[ACC_W-1]}}, acc[ACC_W-1:DATA_W]};
endmodule

// File: tb/sim_mac40_unit.sv
module sim_mac40_unit;
  logic        clk = 1'b0;
  logic        rst_n, op_valid, sel_a_hi, sel_b_hi, clear;
  logic [2:0]  op_code;
  logic [31:0] op_a, op_b, rd_lo, rd_hi;
  logic        ready;
  logic [39:0] acc_out;

  always #5 clk = ~clk;

  mac40_unit u0 (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .op_a(op_a), .op_b(op_b), .sel_a_hi(sel_a_hi), .sel_b_hi(sel_b_hi),
    .clear(clear), .ready(ready), .acc_out(acc_out), .rd_lo(rd_lo), .rd_hi(rd_hi)
  );

  typedef struct {
    int          due;
    logic [39:0] acc;
    logic        rdy;
    bit          chk_acc;
    string       tag;
  } item_t;

  item_t       sb_q[$];
  int          cyc = 0, checks = 0, errors = 0;
  bit          done = 1'b0;
  logic [39:0] model = '0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [39:0] sx16(input logic [15:0] x, input logic [15:0] y);
    logic signed [31:0] p;
    p = $signed(x) * $signed(y);
    return {{8{p[31]}}, p};
  endfunction

  function automatic logic [39:0] wide40(input logic [31:0] x, input logic [31:0] y);
    logic signed [63:0] p;
    p = $signed({{32{x[31]}}, x}) * $signed({{32{y[31]}}, y});
    return p[39:0];
  endfunction

  // Monitor: compare each expected item in the cycle it falls due.
  always @(negedge clk) begin
    while (sb_q.size() > 0 && sb_q[0].due == cyc) begin
      item_t it;
      it = sb_q.pop_front();
      checks++;
      if (ready !== it.rdy) begin
        errors++;
        $display("FAIL %s ready: got %0b expected %0b", it.tag, ready, it.rdy);
      end
      if (it.chk_acc) begin
        checks++;
        if (acc_out !== it.acc) begin
          errors++;
          $display("FAIL %s acc: got %h expected %h", it.tag, acc_out, it.acc);
        end
        checks++;
        if (rd_lo !== it.acc[31:0] || rd_hi !== {{24{it.acc[39]}}, it.acc[39:32]}) begin
          errors++;
          $display("FAIL R6 split (%s): got %h_%h expected %h_%h", it.tag, rd_hi, rd_lo,
                   {{24{it.acc[39]}}, it.acc[39:32]}, it.acc[31:0]);
        end
      end
    end
  end

  task automatic idle_inputs();
    op_valid = 1'b0; clear = 1'b0; op_code = 3'd0;
  endtask

  // Driver. wmode for the 32x32 step cycle: 0 idle, 1 stray load, 2 clear.
  task automatic issue(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b,
                       input bit sa, input bit sb, input bit clr, input int wmode,
                       input string tag);
    op_valid = 1'b1; op_code = op; op_a = a; op_b = b;
    sel_a_hi = sa; sel_b_hi = sb; clear = clr;
    if (op == 3'd3 && !clr) begin
      sb_q.push_back('{cyc + 1, 40'd0, 1'b0, 1'b0, {tag, " busy"}});
      @(posedge clk); @(negedge clk);
      idle_inputs();
      if (wmode == 1) begin
        op_valid = 1'b1; op_code = 3'd4; op_a = 32'hDEAD_BEEF; op_b = 32'h0000_0055;
      end else if (wmode == 2) begin
        clear = 1'b1;
      end
      model = (wmode == 2) ? 40'd0 : model + wide40(a, b);
      sb_q.push_back('{cyc + 1, model, 1'b1, 1'b1, tag});
    end else begin
      if (clr) model = '0;
      else case (op)
        3'd1: model = model + sx16(sa ? a[31:16] : a[15:0], sb ? b[31:16] : b[15:0]);
        3'd2: model = model + sx16(a[31:16], b[31:16]) + sx16(a[15:0], b[15:0]);
        3'd4: model = {b[7:0], a};
        default: ;
      endcase
      sb_q.push_back('{cyc + 1, model, 1'b1, 1'b1, tag});
    end
    @(posedge clk); @(negedge clk);
    idle_inputs();
  endtask

  initial begin
    #1500000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; idle_inputs(); op_a = '0; op_b = '0; sel_a_hi = 0; sel_b_hi = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    checks++;
    if (acc_out !== 40'd0 || ready !== 1'b1) begin
      errors++;
      $display("FAIL R1 reset: got %h/%0b expected 0/1", acc_out, ready);
    end
    // R2: all four half pairings
    issue(3'd1, 32'hFFFE_0005, 32'h0007_FFFD, 0, 0, 0, 0, "R2 lo/lo");
    issue(3'd1, 32'hFFFE_0005, 32'h0007_FFFD, 1, 1, 0, 0, "R2 hi/hi");
    issue(3'd1, 32'hFFFE_0005, 32'h0007_FFFD, 1, 0, 0, 0, "R2 hi/lo");
    issue(3'd1, 32'hFFFE_0005, 32'h0007_FFFD, 0, 1, 0, 0, "R2 lo/hi");
    // R3: dual products, half selects ignored
    issue(3'd2, 32'h8000_7FFF, 32'h8000_7FFF, 1, 0, 0, 0, "R3 dual extremes");
    issue(3'd2, 32'hFFFF_0003, 32'h0009_FFF9, 0, 1, 0, 0, "R3 dual mixed");
    // R7 load, then R4 wide products
    issue(3'd4, 32'h1357_9BDF, 32'hABCD_EFC2, 0, 0, 0, 0, "R7 load");
    issue(3'd3, 32'hFFFF_FFF3, 32'h1234_5678, 0, 0, 0, 0, "R4 wide neg");
    issue(3'd3, 32'h7FFF_FFFF, 32'h8000_0001, 0, 0, 0, 0, "R4 wide extremes");
    issue(3'd3, 32'h8000_0000, 32'h8000_0000, 0, 0, 0, 0, "R4 wide min*min");
    // R5: stray load during the busy cycle is dropped
    issue(3'd3, 32'h0001_2345, 32'hFFFE_DCBA, 0, 0, 0, 1, "R5 ignore while busy");
    // R10: unused opcodes and no-valid cycles
    issue(3'd0, 32'h1111_1111, 32'h2222_2222, 1, 1, 0, 0, "R10 nop");
    issue(3'd5, 32'h1111_1111, 32'h2222_2222, 1, 1, 0, 0, "R10 op5");
    issue(3'd7, 32'h1111_1111, 32'h2222_2222, 1, 1, 0, 0, "R10 op7");
    // R8: wrap past the top of the 40-bit range
    issue(3'd4, 32'hFFFF_FFFF, 32'h0000_007F, 0, 0, 0, 0, "R8 load max");
    issue(3'd1, 32'h0000_0001, 32'h0000_0001, 0, 0, 0, 0, "R8 wrap positive");
    issue(3'd4, 32'hFFFF_FFFF, 32'h0000_00FF, 0, 0, 0, 0, "R8 load -1");
    issue(3'd1, 32'h0000_0002, 32'h0000_0001, 0, 0, 0, 0, "R8 wrap to 1");
    // R9: clear beats an offered op, and cancels a pending wide step
    issue(3'd1, 32'h0000_0100, 32'h0000_0100, 0, 0, 1, 0, "R9 clear over op");
    issue(3'd4, 32'h0F0F_0F0F, 32'h0000_0012, 0, 0, 0, 0, "R9 preload");
    issue(3'd3, 32'h0000_7001, 32'h0003_0005, 0, 0, 0, 2, "R9 clear cancels wide");
    repeat (4) @(negedge clk);
    checks++;
    if (sb_q.size() != 0) begin
      errors++;
      $display("FAIL scoreboard: got %0d pending expected 0", sb_q.size());
    end
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule